// File: doc/BRIEF.md
# Three-Sample Switch Debouncer

This block cleans up the signal from a mechanical contact that chatters when it opens or closes. On every rising clock edge it takes one sample of the raw contact level. The filtered output goes high only once three samples in a row have been high. It then stays high for as long as the samples stay high. A single low sample, at any point, sends the machine back to its idle state and clears the output.

The block is a four-state Moore machine held in a 2-bit register with plain binary state numbering. The states are idle, one high seen, two high seen, and held. The output is decoded from the held state alone, so it changes only on a clock edge and never follows the raw input between edges. The raw input is a plain level pin. It has no valid/ready handshake because it carries no stream: one sample is consumed on every edge and no back-pressure applies. The caller has to deliver the raw level already synchronous to `clk`.

Top module: `sw_debounce`

## Requirements
- R1: While `rst` is high the machine is in the idle state and `clean_out` is 0. A rise of `rst` between clock edges drives `clean_out` low without waiting for an edge.
- R2: A low `raw_in` sampled at any rising edge puts the machine in the idle state, so `clean_out` is 0 after that edge.
- R3: Each high sample moves the machine one step forward: idle to one-seen, one-seen to two-seen, two-seen to held.
- R4: `clean_out` is 1 only in the held state. It first rises after the rising edge that samples the third consecutive high `raw_in`, and it is 0 after the first and second such edges.
- R5: In the held state, every further high sample keeps the machine held, so `clean_out` stays 1.
- R6: A single low sample after one or two high samples restarts the count. The output then rises only after three new consecutive high samples.
- R7: A high pulse that lasts one or two clock samples, with low samples on both sides, never sets `clean_out` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| raw_in | input | 1 | Raw contact level, synchronous to clk |
| clean_out | output | 1 | Debounced level, high only in the held state |

## Verification
The assertions check, on every cycle, the local rules of the machine. These are: a low sample always clears the output on the next cycle, each high sample moves the state one step, the held state survives a high sample, and no rise of the output comes without three high samples just before it. The reset check holds the output low for the whole time reset is applied. Only the bench's scenarios show the longer behaviour. That covers a count restarting after a one-cycle dropout, short one- and two-cycle pulses producing nothing, a long hold, and the reset clearing the output between clock edges.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'd0,
    ST_SEEN1 = 2'd1,
    ST_SEEN2 = 2'd2,
    ST_HELD  = 2'd3
  } state_t;
endpackage

// File: rtl/dbn_next_state.sv
module dbn_next_state
  import dbn_pkg::*;
(
  input  state_t cur_state,
  input  logic   sample,
  output state_t nxt_state
);
  always_comb begin
    nxt_state = ST_IDLE;
    if (sample) begin
      unique case (cur_state)
        ST_IDLE:  nxt_state = ST_SEEN1;
        ST_SEEN1: nxt_state = ST_SEEN2;
        ST_SEEN2: nxt_state = ST_HELD;
        ST_HELD:  nxt_state = ST_HELD;
        default:  nxt_state = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbn_state_reg.sv
module dbn_state_reg
  import dbn_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t d_state,
  output state_t q_state
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) q_state <= ST_IDLE;
    else     q_state <= d_state;
  end
endmodule

// File: rtl/dbn_out_decode.sv
module dbn_out_decode
  import dbn_pkg::*;
(
  input  state_t cur_state,
  output logic   level
);
  always_comb level = (cur_state == ST_HELD);
endmodule

// File: rtl/sw_debounce.sv
module sw_debounce
  import dbn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic clean_out
);
  state_t state_q;
  state_t state_d;

  dbn_next_state u_next (
    .cur_state (state_q),
    .sample    (raw_in),
    .nxt_state (state_d)
  );

  dbn_state_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .d_state (state_d),
    .q_state (state_q)
  );

  dbn_out_decode u_out (
    .cur_state (state_q),
    .level     (clean_out)
  );
endmodule

// File: rtl/dbn_checker.sv
module dbn_checker
  import dbn_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   raw_in,
  input logic   clean_out,
  input state_t state_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !clean_out); // R1

  AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !raw_in |=> (!clean_out && state_q == ST_IDLE)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (raw_in && state_q == ST_IDLE) |=> state_q == ST_SEEN1); // R3

  AST_STEP_TWO: assert property (@(posedge clk) disable iff (rst)
    (raw_in && state_q == ST_SEEN1) |=> state_q == ST_SEEN2); // R3

  AST_STEP_HELD: assert property (@(posedge clk) disable iff (rst)
    (raw_in && state_q == ST_SEEN2) |=> clean_out); // R4

  AST_RISE_NEEDS_THREE: assert property (@(posedge clk) disable iff (rst)
    $rose(clean_out) |-> ($past(raw_in, 1) && $past(raw_in, 2) && $past(raw_in, 3))); // R4

  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (rst)
    (clean_out && raw_in) |=> clean_out); // R5
endmodule

bind sw_debounce dbn_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .raw_in    (raw_in),
  .clean_out (clean_out),
  .state_q   (state_q)
);

// File: tb/sw_debounce_tb.sv
module sw_debounce_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_in = 1'b0;
  logic clean_out;

  int total = 0;
  int bad = 0;
  int run_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_debounce dut_i (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (raw_in),
    .clean_out (clean_out)
  );

  task automatic check(input logic exp, input string req);
    total++;
    if (clean_out !== exp) begin
      bad++;
      $display("FAIL %s: clean_out=%b expected=%b at %0t", req, clean_out, exp, $time);
    end
  endtask

  // drive one sample, then check the output a quarter period after the edge
  task automatic feed(input logic v, input string req);
    @(negedge clk);
    raw_in = v;
    @(posedge clk);
    #(CLK_PERIOD/4);
    run_len = v ? ((run_len < 3) ? run_len + 1 : 3) : 0;
    check(run_len == 3, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(1'b0, "R1");
    raw_in = 1'b1;
    @(negedge clk);
    check(1'b0, "R1");
    rst = 1'b0;
    run_len = 0;
    feed(1'b0, "R1");
  endtask

  task automatic t_rise_on_third();
    feed(1'b1, "R3");
    feed(1'b1, "R3");
    feed(1'b1, "R4");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 6; i++) feed(1'b1, "R5");
  endtask

  task automatic t_drop();
    feed(1'b0, "R2");
    feed(1'b0, "R2");
  endtask

  task automatic t_glitch_restart();
    feed(1'b1, "R6");
    feed(1'b1, "R6");
    feed(1'b0, "R6");
    feed(1'b1, "R6");
    feed(1'b1, "R6");
    feed(1'b1, "R6");
    feed(1'b0, "R2");
  endtask

  task automatic t_short_pulses();
    feed(1'b1, "R7");
    feed(1'b0, "R7");
    feed(1'b1, "R7");
    feed(1'b1, "R7");
    feed(1'b0, "R7");
    feed(1'b1, "R7");
    feed(1'b0, "R7");
  endtask

  task automatic t_async_reset();
    for (int i = 0; i < 4; i++) feed(1'b1, "R5");
    @(negedge clk);
    #(CLK_PERIOD/8);
    rst = 1'b1;
    #1;
    check(1'b0, "R1");
    raw_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    run_len = 0;
    feed(1'b1, "R1");
    feed(1'b1, "R1");
    feed(1'b1, "R1");
    feed(1'b0, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rise_on_third();
    t_hold();
    t_drop();
    t_glitch_restart();
    t_short_pulses();
    t_async_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule